// File: doc/BRIEF.md
# IN Endpoint Ready/Pending Arbiter

This block keeps, for each device endpoint, the two flags that decide whether an IN buffer may be collected by the host: `ready` (the buffer is armed for transmission) and `pending` (hardware cancelled or refused an armed buffer, and software must look at it again). Software arms, retracts and acknowledges through per-endpoint strobes. The packet engine reports host ACKs, SETUP arrivals and bus resets.

The block also counts the SETUP packets that sit unread in the receive queue. It does this from the queue's push and pop strobes, each of which carries a SETUP tag. If software tries to arm a buffer while that count is nonzero, or while a latched bus-reset flag is still set, the request is turned into a cancellation. So a SETUP that arrives just before the arming write leaves the same state as one that arrives just after it. The packet engine, the queue storage and the register decoding are outside this block.

Top module: `in_ep_arbiter`

## Requirements
- R1: After reset, every `rdy_o` and `pend_o` bit, `lrst_o` and `setup_cnt_o` are 0.
- R2: A `sw_rdy_set_i` bit sets the matching `rdy_o` bit on the next cycle when the SETUP count is 0, `lrst_o` is 0 and no cancel event occurs. A `sw_rdy_clr_i` bit clears it.
- R3: `hw_ack_i` with endpoint number `hw_ack_ep_i` (binary index) clears that endpoint's `rdy_o` and leaves `pend_o` unchanged. An ACK for an endpoint that is not ready changes nothing.
- R4: `hw_setup_i` on an endpoint whose `setup_en_i` bit is 1 clears that endpoint's `rdy_o` and sets its `pend_o`. If the enable bit is 0, the SETUP has no effect on the flags.
- R5: `hw_link_reset_i` clears every `rdy_o` bit, sets `pend_o` on each endpoint whose ready was cleared by it, and sets `lrst_o`.
- R6: While `setup_cnt_o` is nonzero, a set-ready request leaves that `rdy_o` bit at 0 and sets its `pend_o` bit.
- R7: While `lrst_o` is 1, a set-ready request is refused in the same way. `sw_lrst_clr_i` clears `lrst_o` (write-1-to-clear), and a link reset in the same cycle wins over the clear.
- R8: `setup_cnt_o` increments on `rxq_push_i` with `rxq_push_setup_i` and decrements on `rxq_pop_i` with `rxq_pop_setup_i`. When both happen in the same cycle, the count is unchanged. Untagged pushes and pops leave it unchanged.
- R9: When a set-ready request and a cancel event (enabled SETUP or link reset) hit the same endpoint in the same cycle, the result is ready 0 and pending 1.
- R10: `sw_pend_clr_i` clears `pend_o` bits (write-1-to-clear). A hardware set in the same cycle wins.
- R11: A set-ready write one cycle before a SETUP push (with its SETUP report) and one cycle after it end in the same ready, pending and count state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_rdy_set_i | input | NUM_EP | Software request to arm the endpoint's IN buffer |
| sw_rdy_clr_i | input | NUM_EP | Software retraction of the armed buffer |
| sw_pend_clr_i | input | NUM_EP | Write-1-to-clear of pending |
| sw_lrst_clr_i | input | 1 | Write-1-to-clear of the link-reset flag |
| setup_en_i | input | NUM_EP | SETUP reception enable per endpoint |
| hw_ack_i | input | 1 | Host ACK of IN data |
| hw_ack_ep_i | input | EP_W | Endpoint of the ACK |
| hw_setup_i | input | 1 | SETUP transaction received |
| hw_setup_ep_i | input | EP_W | Endpoint of the SETUP |
| hw_link_reset_i | input | 1 | Bus reset detected |
| rxq_push_i | input | 1 | Receive queue push |
| rxq_push_setup_i | input | 1 | The pushed entry is a SETUP |
| rxq_pop_i | input | 1 | Receive queue pop by software |
| rxq_pop_setup_i | input | 1 | The popped entry is a SETUP |
| rdy_o | output | NUM_EP | Ready flags |
| pend_o | output | NUM_EP | Pending flags |
| lrst_o | output | 1 | Latched link-reset flag |
| setup_cnt_o | output | CNT_W | Unread SETUP count |

## Verification
The assertions check the local rules on every cycle: a link reset empties ready and latches the flag, a refused arming never shows up in ready and always shows up in pending, an enabled SETUP cancels its endpoint, and the counter steps by exactly one. The assertions cannot show that two orderings of the same events reach the same state, nor that a disabled SETUP or an ACK to an idle endpoint leaves the flags alone. Only the bench's scenarios show these, the ordering race in particular.

// File: rtl/in_ep_arbiter.sv
module in_ep_arbiter #(
  parameter int NUM_EP    = 12,
  parameter int RXQ_DEPTH = 8,
  localparam int EP_W  = $clog2(NUM_EP),
  localparam int CNT_W = $clog2(RXQ_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EP-1:0] sw_rdy_set_i,
  input  logic [NUM_EP-1:0] sw_rdy_clr_i,
  input  logic [NUM_EP-1:0] sw_pend_clr_i,
  input  logic              sw_lrst_clr_i,
  input  logic [NUM_EP-1:0] setup_en_i,
  input  logic              hw_ack_i,
  input  logic [EP_W-1:0]   hw_ack_ep_i,
  input  logic              hw_setup_i,
  input  logic [EP_W-1:0]   hw_setup_ep_i,
  input  logic              hw_link_reset_i,
  input  logic              rxq_push_i,
  input  logic              rxq_push_setup_i,
  input  logic              rxq_pop_i,
  input  logic              rxq_pop_setup_i,
  output logic [NUM_EP-1:0] rdy_o,
  output logic [NUM_EP-1:0] pend_o,
  output logic              lrst_o,
  output logic [CNT_W-1:0]  setup_cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = CNT_W'(RXQ_DEPTH);

  logic [NUM_EP-1:0] rdy_q, pend_q;
  logic              lrst_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [NUM_EP-1:0] setup_hit, ack_hit, lr_mask, cancel, refuse;
  logic              block_arm, cnt_up, cnt_dn;

  assign setup_hit = (hw_setup_i && (32'(hw_setup_ep_i) < NUM_EP))
                     ? ((NUM_EP'(1) << hw_setup_ep_i) & setup_en_i) : '0;
  assign ack_hit   = (hw_ack_i && (32'(hw_ack_ep_i) < NUM_EP))
                     ? (NUM_EP'(1) << hw_ack_ep_i) : '0;
  assign lr_mask   = {NUM_EP{hw_link_reset_i}};
  assign block_arm = (cnt_q != '0) | lrst_q;
  assign cancel    = setup_hit | lr_mask;
  assign refuse    = sw_rdy_set_i & {NUM_EP{block_arm}};

  assign cnt_up = rxq_push_i & rxq_push_setup_i;
  assign cnt_dn = rxq_pop_i & rxq_pop_setup_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= '0;
      pend_q <= '0;
      lrst_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      rdy_q  <= ~(cancel | refuse)
                & (sw_rdy_set_i | (rdy_q & ~sw_rdy_clr_i & ~ack_hit));
      pend_q <= setup_hit | (lr_mask & (rdy_q | sw_rdy_set_i)) | refuse
                | (pend_q & ~sw_pend_clr_i);
      lrst_q <= hw_link_reset_i | (lrst_q & ~sw_lrst_clr_i);
      if (cnt_up && !cnt_dn && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
      else if (cnt_dn && !cnt_up && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rdy_o       = rdy_q;
  assign pend_o      = pend_q;
  assign lrst_o      = lrst_q;
  assign setup_cnt_o = cnt_q;
endmodule

module in_ep_arbiter_chk #(
  parameter int NUM_EP    = 12,
  parameter int RXQ_DEPTH = 8,
  localparam int EP_W  = $clog2(NUM_EP),
  localparam int CNT_W = $clog2(RXQ_DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_EP-1:0] sw_rdy_set_i,
  input logic [NUM_EP-1:0] setup_en_i,
  input logic              hw_setup_i,
  input logic [EP_W-1:0]   hw_setup_ep_i,
  input logic              hw_link_reset_i,
  input logic              rxq_push_i,
  input logic              rxq_push_setup_i,
  input logic              rxq_pop_i,
  input logic              rxq_pop_setup_i,
  input logic [NUM_EP-1:0] rdy_o,
  input logic [NUM_EP-1:0] pend_o,
  input logic              lrst_o,
  input logic [CNT_W-1:0]  setup_cnt_o
);
  assert_link_reset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_link_reset_i |=> (rdy_o == '0) && lrst_o);

  assert_refuse_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|sw_rdy_set_i) && setup_cnt_o != '0) |=>
      ((rdy_o & $past(sw_rdy_set_i)) == '0) &&
      ((pend_o & $past(sw_rdy_set_i)) == $past(sw_rdy_set_i)));

  assert_refuse_lrst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|sw_rdy_set_i) && lrst_o) |=>
      ((rdy_o & $past(sw_rdy_set_i)) == '0) &&
      ((pend_o & $past(sw_rdy_set_i)) == $past(sw_rdy_set_i)));

  assert_setup_cancel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_setup_i && (32'(hw_setup_ep_i) < NUM_EP) && setup_en_i[hw_setup_ep_i]) |=>
      !rdy_o[$past(hw_setup_ep_i)] && pend_o[$past(hw_setup_ep_i)]);

  assert_cnt_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxq_push_i && rxq_push_setup_i && !(rxq_pop_i && rxq_pop_setup_i)
     && setup_cnt_o != CNT_W'(RXQ_DEPTH)) |=> setup_cnt_o == $past(setup_cnt_o) + 1'b1);

  assert_cnt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxq_push_i && rxq_push_setup_i && rxq_pop_i && rxq_pop_setup_i) |=> $stable(setup_cnt_o));
endmodule

bind in_ep_arbiter in_ep_arbiter_chk #(.NUM_EP(NUM_EP), .RXQ_DEPTH(RXQ_DEPTH)) u_chk (.*);

// File: tb/sim_in_ep_arbiter.sv
module sim_in_ep_arbiter;
  localparam int N = 12;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [N-1:0] set_m = '0, clr_m = '0, pclr_m = '0, sen = '1;
  logic lclr = 0, ack = 0, stp = 0, lr = 0, push = 0, push_s = 0, pop = 0, pop_s = 0;
  logic [3:0] ack_ep = '0, stp_ep = '0;
  logic [N-1:0] rdy, pend;
  logic lrst;
  logic [3:0] cnt;

  int checks = 0, fails = 0;

  in_ep_arbiter #(.NUM_EP(N), .RXQ_DEPTH(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rdy_set_i(set_m), .sw_rdy_clr_i(clr_m),
    .sw_pend_clr_i(pclr_m), .sw_lrst_clr_i(lclr), .setup_en_i(sen),
    .hw_ack_i(ack), .hw_ack_ep_i(ack_ep), .hw_setup_i(stp), .hw_setup_ep_i(stp_ep),
    .hw_link_reset_i(lr), .rxq_push_i(push), .rxq_push_setup_i(push_s),
    .rxq_pop_i(pop), .rxq_pop_setup_i(pop_s), .rdy_o(rdy), .pend_o(pend),
    .lrst_o(lrst), .setup_cnt_o(cnt));

  typedef struct packed {
    logic [11:0] set_v, clr_v, pclr_v;
    logic ack_v; logic [3:0] ack_ep_v;
    logic stp_v; logic [3:0] stp_ep_v;
    logic [11:0] exp_rdy, exp_pend;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{12'h009, 12'h000, 12'h000, 1'b0, 4'd0, 1'b0, 4'd0, 12'h009, 12'h000},
    '{12'h000, 12'h000, 12'h000, 1'b1, 4'd3, 1'b0, 4'd0, 12'h001, 12'h000},
    '{12'h000, 12'h000, 12'h000, 1'b1, 4'd5, 1'b0, 4'd0, 12'h001, 12'h000},
    '{12'h000, 12'h000, 12'h000, 1'b0, 4'd0, 1'b1, 4'd0, 12'h000, 12'h001},
    '{12'h080, 12'h000, 12'h001, 1'b0, 4'd0, 1'b0, 4'd0, 12'h080, 12'h000},
    '{12'h000, 12'h080, 12'h000, 1'b0, 4'd0, 1'b0, 4'd0, 12'h000, 12'h000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    set_m = '0; clr_m = '0; pclr_m = '0; lclr = 0; ack = 0; stp = 0; lr = 0;
    push = 0; push_s = 0; pop = 0; pop_s = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  logic [N-1:0] ra, pa;
  logic [3:0] ca;

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdy", 32'(rdy), 0); chk("R1 pend", 32'(pend), 0);
    chk("R1 lrst", 32'(lrst), 0); chk("R1 cnt", 32'(cnt), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4 R10 via table
    foreach (TBL[i]) begin
      set_m = TBL[i].set_v; clr_m = TBL[i].clr_v; pclr_m = TBL[i].pclr_v;
      ack = TBL[i].ack_v; ack_ep = TBL[i].ack_ep_v;
      stp = TBL[i].stp_v; stp_ep = TBL[i].stp_ep_v;
      tick();
      chk($sformatf("R2/R3/R4 vec%0d rdy", i), 32'(rdy), 32'(TBL[i].exp_rdy));
      chk($sformatf("R2/R3/R4 vec%0d pend", i), 32'(pend), 32'(TBL[i].exp_pend));
    end

    // R4 disabled SETUP has no effect
    set_m = 12'h004; tick();
    sen = ~12'h004; stp = 1; stp_ep = 4'd2; tick();
    chk("R4 disabled rdy", 32'(rdy), 32'h004); chk("R4 disabled pend", 32'(pend), 0);
    sen = '1; clr_m = 12'h004; tick();

    // R5 link reset
    set_m = 12'h012; tick();
    lr = 1; tick();
    chk("R5 rdy", 32'(rdy), 0); chk("R5 pend", 32'(pend), 32'h012); chk("R5 lrst", 32'(lrst), 1);
    // R7 refusal while flag set
    pclr_m = '1; tick();
    set_m = 12'h002; tick();
    chk("R7 refused rdy", 32'(rdy), 0); chk("R7 refused pend", 32'(pend), 32'h002);
    lclr = 1; lr = 1; tick();
    chk("R7 set wins over clear", 32'(lrst), 1);
    lclr = 1; tick();
    chk("R7 cleared", 32'(lrst), 0);
    pclr_m = '1; set_m = 12'h002; tick();
    chk("R7 armed after clear", 32'(rdy), 32'h002); chk("R7 pend cleared", 32'(pend), 0);
    clr_m = '1; tick();

    // R8 counter
    push = 1; push_s = 1; tick(); chk("R8 inc", 32'(cnt), 1);
    push = 1; tick(); chk("R8 untagged push", 32'(cnt), 1);
    push = 1; push_s = 1; pop = 1; pop_s = 1; tick(); chk("R8 both", 32'(cnt), 1);
    // R6 refusal while SETUP queued
    set_m = 12'h020; tick();
    chk("R6 rdy", 32'(rdy), 0); chk("R6 pend", 32'(pend), 32'h020);
    pop = 1; tick(); chk("R8 untagged pop", 32'(cnt), 1);
    pop = 1; pop_s = 1; tick(); chk("R8 dec", 32'(cnt), 0);
    pclr_m = '1; tick();

    // R9 cancel wins
    set_m = 12'h040; stp = 1; stp_ep = 4'd6; tick();
    chk("R9 setup rdy", 32'(rdy), 0); chk("R9 setup pend", 32'(pend), 32'h040);
    pclr_m = '1; set_m = 12'h100; lr = 1; tick();
    chk("R9 reset rdy", 32'(rdy), 0); chk("R9 reset pend", 32'(pend), 32'h100);
    lclr = 1; tick();

    // R10 hardware set wins over W1C
    pclr_m = 12'h100; stp = 1; stp_ep = 4'd8; tick();
    chk("R10 set wins", 32'(pend), 32'h100);
    pclr_m = '1; tick();
    chk("R10 cleared", 32'(pend), 0);

    // R11 ordering A: arm then SETUP
    set_m = 12'h001; tick();
    stp = 1; stp_ep = 4'd0; push = 1; push_s = 1; tick();
    ra = rdy; pa = pend; ca = cnt;
    pop = 1; pop_s = 1; tick();
    pclr_m = '1; tick();
    // ordering B: SETUP then arm
    stp = 1; stp_ep = 4'd0; push = 1; push_s = 1; tick();
    set_m = 12'h001; tick();
    chk("R11 rdy", 32'(rdy), 32'(ra)); chk("R11 pend", 32'(pend), 32'(pa));
    chk("R11 cnt", 32'(cnt), 32'(ca));
    chk("R11 abs", {20'h0, rdy}, 0); chk("R11 abs pend", 32'(pend), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule